// File: doc/BRIEF.md
# Output-Compare Channel with Pin Action

This block is one channel of a timer's output-compare unit. Software loads a 16-bit compare value through a byte-wide register bus, one half at a time. Every clock cycle the channel checks that value against a free-running counter supplied from outside. When the two are equal, it raises a match strobe, latches a sticky match flag and requests an action on its output pin.

Two select bits choose the pin action: leave the pin alone, toggle it, drive it low or drive it high. A force strobe requests the selected action at once, without waiting for a match. The pin multiplexer downstream consumes the three request lines.

Loading the upper half of the compare value blocks matching for the next cycle only. This gives software time to load the lower half, so a value that is half old and half new cannot produce a spurious match.

Top module: `ocmp_chan`

## Requirements
- R1: The compare value is 16 bits, read and written as two bytes: `addr`=0 selects the upper byte and `addr`=1 the lower byte. A write stores `wdata` into the selected byte at the clock edge.
- R2: After reset the compare value reads 0xFFFF, the match flag is 0 and no strobe or pin request is active.
- R3: In the cycle that follows a write to the upper byte, `match_stb` stays low even when the counter equals the stored value. From the cycle after that, matching works normally again.
- R4: `match_stb` is high in any cycle, other than an inhibited one, in which `cnt` equals the stored compare value.
- R5: Pin requests use the encoding of `act_sel`: 00 = no request, 01 = `pin_toggle`, 10 = `pin_clear`, 11 = `pin_set`. At most one request line is high at a time.
- R6: A high `force_req` raises the request line selected by `act_sel` in that same cycle, whatever the counter value.
- R7: A forced action does not set the match flag.
- R8: A write to the lower byte does not inhibit matching. The full new value is compared from the cycle after that write.
- R9: A match sets `match_flag` at the next clock edge, and the flag stays set until software writes 1 to bit 0 at `addr`=2. Writing 0 there leaves the flag unchanged. If a match and a clear happen in the same cycle, the set wins.
- R10: Reads are combinational: `addr` 0 and 1 return the stored bytes, `addr` 2 returns the flag in bit 0, and `addr` 3 returns 0. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 upper byte, 1 lower byte, 2 flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cnt | input | 16 | Free-running counter value |
| act_sel | input | 2 | Pin action select |
| force_req | input | 1 | Force the selected action now |
| match_stb | output | 1 | Compare match this cycle |
| match_flag | output | 1 | Sticky match flag |
| pin_toggle | output | 1 | Request: toggle pin |
| pin_clear | output | 1 | Request: drive pin low |
| pin_set | output | 1 | Request: drive pin high |

## Verification
The bench builds the block with its default byte width of 8, so the compare value is 16 bits. At that width the bench can load mixed values such as 0x12FF and 0x34FF, where changing only the upper byte turns a mismatch into a match. That case shows the single inhibited cycle and the recovery one cycle later. The same width makes the reset value 0xFFFF and the same-cycle set-versus-clear race on the flag easy to reach with short directed sequences.

// File: rtl/ocmp_chan.sv
module ocmp_chan #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic [2*BYTE_W-1:0] cnt,
  input  logic [1:0]          act_sel,
  input  logic                force_req,
  output logic                match_stb,
  output logic                match_flag,
  output logic                pin_toggle,
  output logic                pin_clear,
  output logic                pin_set
);
  localparam int CW = 2 * BYTE_W;
  localparam logic [1:0] A_HI  = 2'd0;
  localparam logic [1:0] A_LO  = 2'd1;
  localparam logic [1:0] A_FLG = 2'd2;

  logic [CW-1:0] cmp_q;
  logic          inh_q;
  logic          flag_q;
  logic          fire;

  wire wr_hi  = wr_en && addr == A_HI;
  wire wr_lo  = wr_en && addr == A_LO;
  wire wr_clr = wr_en && addr == A_FLG && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      inh_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_hi) cmp_q[CW-1:BYTE_W] <= wdata;
      if (wr_lo) cmp_q[BYTE_W-1:0]  <= wdata;
      inh_q <= wr_hi;
      if (match_stb)   flag_q <= 1'b1;
      else if (wr_clr) flag_q <= 1'b0;
    end
  end

  assign match_stb  = (cmp_q == cnt) && !inh_q;
  assign match_flag = flag_q;
  assign fire       = match_stb || force_req;
  assign pin_toggle = fire && act_sel == 2'b01;
  assign pin_clear  = fire && act_sel == 2'b10;
  assign pin_set    = fire && act_sel == 2'b11;

  always_comb begin
    case (addr)
      A_HI:    rdata = cmp_q[CW-1:BYTE_W];
      A_LO:    rdata = cmp_q[BYTE_W-1:0];
      A_FLG:   rdata = {{(BYTE_W-1){1'b0}}, flag_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ocmp_chan_chk.sv
module ocmp_chan_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          addr,
  input logic [2*BYTE_W-1:0] cmp_q,
  input logic                force_req,
  input logic                match_stb,
  input logic                match_flag,
  input logic                pin_toggle,
  input logic                pin_clear,
  input logic                pin_set
);
  p_reset_val_r2: assert property (@(posedge clk) !rst_n |=> cmp_q == '1);

  p_hi_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> !match_stb);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |=> match_flag);

  p_one_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pin_toggle, pin_clear, pin_set}));

  p_force_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && !match_stb && !match_flag) |=> !match_flag);
endmodule

bind ocmp_chan ocmp_chan_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .cmp_q(cmp_q),
  .force_req(force_req), .match_stb(match_stb), .match_flag(match_flag),
  .pin_toggle(pin_toggle), .pin_clear(pin_clear), .pin_set(pin_set)
);

// File: tb/ocmp_chan_test.sv
`timescale 1ns/1ps
module ocmp_chan_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [15:0] cnt = 16'h0000;
  logic [1:0]  act_sel = 0;
  logic        force_req = 0;
  logic        match_stb, match_flag, pin_toggle, pin_clear, pin_set;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ocmp_chan uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt(cnt), .act_sel(act_sel), .force_req(force_req),
    .match_stb(match_stb), .match_flag(match_flag), .pin_toggle(pin_toggle),
    .pin_clear(pin_clear), .pin_set(pin_set)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 2'd3;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R2 hi", d, 8'hFF);
    rd(2'd1, d); chk("R2 lo", d, 8'hFF);
    chk("R2 flag", match_flag, 0);
    chk("R2 reqs", {match_stb, pin_toggle, pin_clear, pin_set}, 0);
  endtask

  task automatic t_rw;
    logic [7:0] d;
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    rd(2'd0, d); chk("R1 hi", d, 8'hA5);
    rd(2'd1, d); chk("R1 lo", d, 8'h3C);
    rd(2'd3, d); chk("R10 addr3", d, 8'h00);
  endtask

  task automatic t_match_flag;
    logic [7:0] d;
    cnt = 16'hA53B; #1;
    chk("R4 no match", match_stb, 0);
    @(negedge clk); cnt = 16'hA53C; #1;
    chk("R4 match", match_stb, 1);
    @(negedge clk); cnt = 16'hA53D; #1;
    chk("R9 flag set", match_flag, 1);
    chk("R4 strobe off", match_stb, 0);
    rd(2'd2, d); @(negedge clk); rd(2'd2, d);
    chk("R10 read keeps flag", d, 8'h01);
    wr(2'd2, 8'h00); #1;
    chk("R9 write 0 keeps", match_flag, 1);
    wr(2'd2, 8'h01); #1;
    chk("R9 clear", match_flag, 0);
  endtask

  task automatic t_actions;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); act_sel = s[1:0]; cnt = 16'hA53C; #1;
      chk("R5 reqs", {pin_toggle, pin_clear, pin_set},
          s == 0 ? 3'b000 : s == 1 ? 3'b100 : s == 2 ? 3'b010 : 3'b001);
    end
    @(negedge clk); cnt = 16'h0000;
    wr(2'd2, 8'h01); #1;
  endtask

  task automatic t_force;
    chk("R7 pre flag", match_flag, 0);
    for (int s = 1; s < 4; s++) begin
      @(negedge clk); act_sel = s[1:0]; force_req = 1; #1;
      chk("R6 force reqs", {pin_toggle, pin_clear, pin_set},
          s == 1 ? 3'b100 : s == 2 ? 3'b010 : 3'b001);
    end
    @(negedge clk); force_req = 0; #1;
    chk("R7 force no flag", match_flag, 0);
    chk("R6 release", {pin_toggle, pin_clear, pin_set}, 0);
  endtask

  task automatic t_inhibit;
    wr(2'd0, 8'h12); wr(2'd1, 8'hFF);
    @(negedge clk); cnt = 16'h34FF; #1;
    chk("R3 pre", match_stb, 0);
    wr(2'd0, 8'h34); #1;
    chk("R3 inhibited", match_stb, 0);
    @(negedge clk); #1;
    chk("R3 recovered", match_stb, 1);
    wr(2'd2, 8'h01); #1;
    chk("R9 set wins", match_flag, 1);
    @(negedge clk); cnt = 16'h0000;
    wr(2'd2, 8'h01); #1;
    chk("R9 cleared", match_flag, 0);
  endtask

  task automatic t_low_write;
    @(negedge clk); cnt = 16'h3477; #1;
    wr(2'd1, 8'h77); #1;
    chk("R8 no inhibit", match_stb, 1);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    t_rw();
    t_match_flag();
    t_actions();
    t_force();
    t_inhibit();
    t_low_write();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule